// File: doc/BRIEF.md
# Fault Escalation and Lockup Monitor

This block tracks the fault state of a small processor core. Each cycle the execution pipeline presents a vector of fault pulses, one bit for each fault cause, together with the handler context the core is running in. Every cause feeds the same top-priority hard-fault exception. The monitor records which causes fired, raises one hard-fault request, and keeps that request up until the core reports that it has entered the hard-fault handler.

When a fault arrives while the core is already in the NMI handler or the hard-fault handler, no new exception can help. The monitor then moves to a lockup state and raises a flag that halts instruction issue. Only an NMI or reset ends lockup. A small priority selector also shows which exception the core should take next: NMI first, then hard fault, then any ordinary pending interrupt.

The controller has three states. RUN means no fault is outstanding. HF_PEND means a hard fault is requested. LOCKED means the core is halted. The transitions are:
- RUN to HF_PEND: a fault arrives in thread or normal-handler context.
- RUN or HF_PEND to LOCKED: a fault arrives in NMI or hard-fault context.
- HF_PEND to RUN: the context reads hard-fault handler and no fault arrives.
- LOCKED to RUN: nmi_i is high.

Top module: `fault_lockup_monitor`

## Requirements
- R1: After reset (asynchronous, active low), hf_req_o and lockup_o are 0 and cause_o is 0.
- R2: A fault (any bit of fault_i set) in context 0 (thread) or 1 (normal handler), while not locked up, sets hf_req_o in the next cycle with lockup_o still 0.
- R3: cause_o bit positions are: 0 undefined instruction, 1 unaligned load or store, 2 bus error, 3 execute-never fetch, 4 supervisor-call priority error, 5 breakpoint without debugger. The cycle after an accepted fault, cause_o equals that cycle's fault_i. It holds its value in every cycle with no fault.
- R4: Several causes in one cycle are all recorded in cause_o and raise only the single hf_req_o request.
- R5: hf_req_o stays high until a cycle in which ctx_i is 3 (hard-fault handler) and no fault arrives. It is 0 from the next cycle. A further fault in context 0 or 1 keeps it high and reloads cause_o.
- R6: A fault in context 2 (NMI handler) or 3 (hard-fault handler), while not locked up, sets lockup_o in the next cycle and clears hf_req_o.
- R7: While locked up, faults are ignored and cause_o and lockup_o hold. lockup_o clears in the cycle after nmi_i is high.
- R8: exc_sel_o is decided in the same cycle from the inputs and state. It is 3 (NMI) when nmi_i is high. Otherwise it is 2 (hard fault) when hf_req_o is high. Otherwise it is 1 (interrupt) when irq_pend_i is high and the core is not locked up. Otherwise it is 0.
- R9: Reset taken while locked up or while a hard fault is pending returns every output to its R1 value at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 6 | Fault pulses, one bit per cause (see R3) |
| ctx_i | input | 2 | Handler context: 0 thread, 1 handler, 2 NMI, 3 hard fault |
| nmi_i | input | 1 | Non-maskable interrupt |
| irq_pend_i | input | 1 | An ordinary interrupt is pending |
| hf_req_o | output | 1 | Hard-fault exception request |
| cause_o | output | 6 | Recorded fault causes |
| lockup_o | output | 1 | Lockup flag; halts instruction issue |
| exc_sel_o | output | 2 | Next exception: 0 none, 1 interrupt, 2 hard fault, 3 NMI |

## Verification
The assertions check the cycle-to-cycle rules on every clock: fault-to-request and fault-to-lockup timing, the hold of the request and of the lockup flag, the stability of the cause register, the exit from lockup through NMI, and the priority of NMI in the selector. They also check that the request and the lockup flag are never high together. Only the bench's scenarios can show that the cause bits land in the stated positions, that a reset taken mid-lockup clears everything, and that long random mixes of contexts, NMIs and faults agree with an independent model.

// File: rtl/fault_pkg.sv
package fault_pkg;

    localparam int unsigned FLT_CAUSES = 6;

    localparam int unsigned FLT_UNDEF   = 0;
    localparam int unsigned FLT_UNALIGN = 1;
    localparam int unsigned FLT_BUSERR  = 2;
    localparam int unsigned FLT_XNEVER  = 3;
    localparam int unsigned FLT_SVCPRI  = 4;
    localparam int unsigned FLT_BKPT    = 5;

    typedef enum logic [1:0] {
        CTX_THREAD  = 2'd0,
        CTX_HANDLER = 2'd1,
        CTX_NMI     = 2'd2,
        CTX_HARD    = 2'd3
    } ctx_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HF_PEND = 2'd1,
        ST_LOCKED  = 2'd2
    } mon_state_e;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_IRQ  = 2'd1,
        EXC_HARD = 2'd2,
        EXC_NMI  = 2'd3
    } exc_e;

    // A context in which a fault cannot be turned into a new exception.
    function automatic logic ctx_escalates(input ctx_e c);
        return (c == CTX_NMI) || (c == CTX_HARD);
    endfunction

endpackage

// File: rtl/fault_capture.sv
module fault_capture #(
    parameter int unsigned N_CAUSE = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CAUSE-1:0] fault_i,
    input  logic               accept_i,
    output logic               any_fault_o,
    output logic [N_CAUSE-1:0] cause_q_o
);

    assign any_fault_o = |fault_i;

    // Every cause present in the accepting cycle is recorded together.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q_o <= '0;
        end else if (accept_i && any_fault_o) begin
            cause_q_o <= fault_i;
        end
    end

endmodule

// File: rtl/fault_fsm.sv
module fault_fsm
    import fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_fault_i,
    input  ctx_e ctx_i,
    input  logic nmi_i,
    output logic hf_req_o,
    output logic locked_o
);

    mon_state_e state_q;
    mon_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (any_fault_i) begin
                    state_d = ctx_escalates(ctx_i) ? ST_LOCKED : ST_HF_PEND;
                end
            end
            ST_HF_PEND: begin
                if (any_fault_i && ctx_escalates(ctx_i)) begin
                    state_d = ST_LOCKED;
                end else if (!any_fault_i && ctx_i == CTX_HARD) begin
                    state_d = ST_RUN;
                end
            end
            ST_LOCKED: begin
                if (nmi_i) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        hf_req_o = 1'b0;
        locked_o = 1'b0;
        unique case (state_q)
            ST_RUN:     ;
            ST_HF_PEND: hf_req_o = 1'b1;
            ST_LOCKED:  locked_o = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/exc_select.sv
module exc_select
    import fault_pkg::*;
(
    input  logic nmi_i,
    input  logic hf_req_i,
    input  logic irq_pend_i,
    input  logic locked_i,
    output exc_e sel_o
);

    always_comb begin
        if (nmi_i) begin
            sel_o = EXC_NMI;
        end else if (hf_req_i) begin
            sel_o = EXC_HARD;
        end else if (irq_pend_i && !locked_i) begin
            sel_o = EXC_IRQ;
        end else begin
            sel_o = EXC_NONE;
        end
    end

endmodule

// File: rtl/fault_lockup_monitor.sv
module fault_lockup_monitor
    import fault_pkg::*;
#(
    parameter int unsigned N_CAUSE = FLT_CAUSES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CAUSE-1:0] fault_i,
    input  logic [1:0]         ctx_i,
    input  logic               nmi_i,
    input  logic               irq_pend_i,
    output logic               hf_req_o,
    output logic [N_CAUSE-1:0] cause_o,
    output logic               lockup_o,
    output logic [1:0]         exc_sel_o
);

    logic any_fault;
    logic locked;
    logic hf_req;
    exc_e sel;

    fault_capture #(.N_CAUSE(N_CAUSE)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_i    (fault_i),
        .accept_i   (!locked),
        .any_fault_o(any_fault),
        .cause_q_o  (cause_o)
    );

    fault_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_fault_i(any_fault),
        .ctx_i      (ctx_e'(ctx_i)),
        .nmi_i      (nmi_i),
        .hf_req_o   (hf_req),
        .locked_o   (locked)
    );

    exc_select u_sel (
        .nmi_i     (nmi_i),
        .hf_req_i  (hf_req),
        .irq_pend_i(irq_pend_i),
        .locked_i  (locked),
        .sel_o     (sel)
    );

    assign hf_req_o  = hf_req;
    assign lockup_o  = locked;
    assign exc_sel_o = sel;

endmodule

// File: rtl/fault_lockup_monitor_chk.sv
module fault_lockup_monitor_chk #(
    parameter int unsigned N_CAUSE = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CAUSE-1:0] fault_i,
    input logic [1:0]         ctx_i,
    input logic               nmi_i,
    input logic               hf_req_o,
    input logic [N_CAUSE-1:0] cause_o,
    input logic               lockup_o,
    input logic [1:0]         exc_sel_o
);

    logic flt;
    logic esc;
    assign flt = |fault_i;
    assign esc = ctx_i[1];

    // R2
    req_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt && !esc && !lockup_o) |=> (hf_req_o && !lockup_o));

    // R6
    lock_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt && esc && !lockup_o) |=> (lockup_o && !hf_req_o));

    // R3
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flt |=> $stable(cause_o));

    // R3
    cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt && !lockup_o) |=> (cause_o == $past(fault_i)));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hf_req_o && ctx_i != 2'd3 && !(flt && esc)) |=> hf_req_o);

    // R5
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hf_req_o && !flt && ctx_i == 2'd3) |=> !hf_req_o);

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lockup_o && !nmi_i) |=> (lockup_o && $stable(cause_o)));

    // R7
    lock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lockup_o && nmi_i) |=> !lockup_o);

    // R6
    excl_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hf_req_o && lockup_o));

    // R8
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_i |-> (exc_sel_o == 2'd3));

endmodule

bind fault_lockup_monitor fault_lockup_monitor_chk #(.N_CAUSE(N_CAUSE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_i  (fault_i),
    .ctx_i    (ctx_i),
    .nmi_i    (nmi_i),
    .hf_req_o (hf_req_o),
    .cause_o  (cause_o),
    .lockup_o (lockup_o),
    .exc_sel_o(exc_sel_o)
);

// File: tb/fault_lockup_monitor_test.sv
`timescale 1ns/1ps
module fault_lockup_monitor_test;

    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] fault_i = '0;
    logic [1:0]   ctx_i = 2'd0;
    logic         nmi_i = 1'b0;
    logic         irq_pend_i = 1'b0;
    logic         hf_req_o;
    logic [N-1:0] cause_o;
    logic         lockup_o;
    logic [1:0]   exc_sel_o;

    int checks = 0;
    int errors = 0;

    // model: 0 run, 1 pending, 2 locked
    int           m_st = 0;
    logic [N-1:0] m_cause = '0;

    always #2.5 clk = ~clk;

    fault_lockup_monitor uut (
        .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .ctx_i(ctx_i),
        .nmi_i(nmi_i), .irq_pend_i(irq_pend_i), .hf_req_o(hf_req_o),
        .cause_o(cause_o), .lockup_o(lockup_o), .exc_sel_o(exc_sel_o)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int exp_sel(input logic nmi, input logic irq, input int st);
        if (nmi) return 3;
        if (st == 1) return 2;
        if (irq && st != 2) return 1;
        return 0;
    endfunction

    function automatic int next_st(input int st, input logic [N-1:0] f,
                                   input logic [1:0] c, input logic nmi);
        if (st == 2) return nmi ? 0 : 2;
        if (|f) return (c >= 2) ? 2 : 1;
        if (st == 1 && c == 2'd3) return 0;
        return st;
    endfunction

    task automatic check_outputs(input string tag);
        check({tag, " R2/R5 hf_req"}, int'(hf_req_o), int'(m_st == 1));
        check({tag, " R6/R7 lockup"}, int'(lockup_o), int'(m_st == 2));
        check({tag, " R3 cause"}, int'(cause_o), int'(m_cause));
    endtask

    task automatic step(input logic [N-1:0] f, input logic [1:0] c,
                        input logic nmi, input logic irq, input string tag);
        @(negedge clk);
        fault_i = f; ctx_i = c; nmi_i = nmi; irq_pend_i = irq;
        #1;
        check({tag, " R8 exc_sel"}, int'(exc_sel_o), exp_sel(nmi, irq, m_st));
        if (m_st != 2 && |f) m_cause = f;
        m_st = next_st(m_st, f, c, nmi);
        @(posedge clk);
        #1;
        check_outputs(tag);
    endtask

    task automatic apply_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        fault_i = '0; nmi_i = 1'b0; irq_pend_i = 1'b0; ctx_i = 2'd0;
        #1;
        m_st = 0; m_cause = '0;
        check_outputs(tag);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        apply_reset("R1 reset");

        // R2 / R3: bus error (bit 2) in thread context
        step(6'b000100, 2'd0, 0, 0, "R2 thread fault");
        check("R3 bus error bit", int'(cause_o[2]), 1);
        // R5: request held while in normal handler, with irq pending
        step('0, 2'd1, 0, 1, "R5 hold");
        step('0, 2'd1, 0, 1, "R5 hold2");
        // R5: another fault in handler keeps request and reloads cause
        step(6'b000001, 2'd1, 0, 0, "R5 refault");
        check("R5 undefined reloaded", int'(cause_o), 1);
        // R5: entering hard-fault handler drops the request
        step('0, 2'd3, 0, 0, "R5 drop");
        check("R5 request low", int'(hf_req_o), 0);
        check("R3 cause held after drop", int'(cause_o), 1);
        // R4: several causes at once
        step(6'b101010, 2'd0, 0, 0, "R4 multi");
        check("R4 all bits recorded", int'(cause_o), 6'b101010);
        check("R4 single request", int'(hf_req_o), 1);
        // R6: fault inside hard-fault handler while pending escalates
        step(6'b010000, 2'd3, 0, 0, "R6 hard ctx fault");
        check("R6 lockup set", int'(lockup_o), 1);
        // R7: fault while locked is ignored
        step(6'b111111, 2'd0, 0, 1, "R7 ignored");
        check("R7 cause unchanged", int'(cause_o), 6'b010000);
        check("R7 still locked", int'(lockup_o), 1);
        // R7: NMI leaves lockup
        step('0, 2'd2, 1, 0, "R7 nmi exit");
        check("R7 lockup cleared", int'(lockup_o), 0);
        // R6: fault in NMI handler from run
        step(6'b001000, 2'd2, 0, 0, "R6 nmi ctx fault");
        // R9: reset while locked
        apply_reset("R9 reset in lockup");
        step(6'b000010, 2'd0, 0, 0, "R9 pend");
        apply_reset("R9 reset in pending");

        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] f;
            f = ($urandom_range(0, 5) == 0) ? N'($urandom_range(1, 63)) : '0;
            step(f, 2'($urandom_range(0, 3)), ($urandom_range(0, 11) == 0),
                 1'($urandom_range(0, 1)), "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule